// File: doc/BRIEF.md
# MII/RMII Receive Adapter

This block sits between the receive side of a 10 Mb/s transceiver and a MAC. Received nibbles arrive from the line side one at a time, each tagged with an error flag and an end-of-frame flag. They go into a small queue. From the queue they are presented to the MAC on one of two receive buses. The first is a 4-bit bus that advances once per 2.5 MHz receive-clock enable. The second is a 2-bit reduced bus that splits every nibble into two dibits, each held for a fixed number of reference-clock enables.

The bus style is chosen by a strap-like configuration input. The block captures that input while reset is asserted and holds it for the rest of operation. A data-valid output frames each packet. It drops for at least one output slot after the final nibble of a frame. It also drops whenever the queue runs dry. While data-valid is low, the data and error outputs are forced to zero.

Top module: `rxa_rx_adapter`

## Requirements
- R1: The bus mode is taken from `cfg_rmii_strap` while `rst` is high (1 selects the 2-bit bus, 0 the 4-bit bus). Changes to the strap after reset is released have no effect on the output format.
- R2: In 4-bit mode, the outputs change only on clock edges where `mii_ce` is high. Each such edge with a queued nibble presents exactly one nibble on `rx_d[3:0]` with `rx_dv` high.
- R3: In 2-bit mode, the outputs change only on edges where `ref_ce` is high. Each nibble appears on `rx_d[1:0]` as bits [1:0] first, then bits [3:2]. Each dibit is held for DIBIT_HOLD (default 10) `ref_ce` edges, so one nibble spans 20.
- R4: In 2-bit mode, `rx_d[3:2]` is always zero.
- R5: While `rx_dv` is low, `rx_d` is zero and `rx_er` is low.
- R6: `rx_er` is high for the full time a nibble marked with `nib_err` is on the bus, and low for nibbles without the mark.
- R7: After the nibble marked `nib_last`, `rx_dv` is low for exactly one output slot, even if the next frame is already queued.
- R8: If no nibble is queued when a slot begins, `rx_dv` is low for that slot.
- R9: Nibbles are delivered in arrival order. Up to FIFO_DEPTH (default 16) may be queued. A `nib_stb` arriving while the queue is full is dropped.
- R10: During and right after reset, `rx_d`, `rx_dv` and `rx_er` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also opens the strap capture |
| cfg_rmii_strap | input | 1 | Bus mode strap, 1 = 2-bit bus |
| mii_ce | input | 1 | One-cycle enable at the 2.5 MHz nibble rate |
| ref_ce | input | 1 | One-cycle enable at the reference-clock rate |
| nib_stb | input | 1 | Line-side nibble present this cycle |
| nib_data | input | 4 | Line-side nibble |
| nib_err | input | 1 | Nibble carries a receive error |
| nib_last | input | 1 | Nibble is the final one of its frame |
| rx_d | output | 4 | Receive data to the MAC |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |

## Verification
The bench queues two frames back to back and expects one idle slot between them. A design that ran frames together would keep `rx_dv` high across the boundary, and one that added more gap would shift every later nibble. The 2-bit tests count dibit lengths exactly and check low-before-high order and the error flag held across both halves. A swapped order, an off-by-one hold or an error that lapses on the second dibit would each show up in specific slots. Further tests fill the queue to its exact depth plus one extra push, flip the strap after reset, and starve the queue mid-frame. These catch a design that overwrites the oldest entry, follows a live strap, or leaves stale data on the bus while valid is low.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  localparam int NIB_W   = 4;
  localparam int DIBIT_W = 2;

  typedef struct packed {
    logic             last;
    logic             err;
    logic [NIB_W-1:0] nib;
  } rxa_ent_t;
endpackage

// File: rtl/rxa_fifo.sv
module rxa_fifo
  import rxa_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wr,
  input  rxa_ent_t wdata,
  input  logic     rd,
  output rxa_ent_t rdata,
  output logic     empty,
  output logic     full
);
  localparam int AW = $clog2(DEPTH);

  rxa_ent_t      mem [DEPTH];
  logic [AW:0]   wptr;
  logic [AW:0]   rptr;
  logic          do_wr;
  logic          do_rd;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rptr[AW-1:0]];

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/rxa_mii_lane.sv
module rxa_mii_lane
  import rxa_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             q_empty,
  input  rxa_ent_t         q_head,
  output logic             q_pop,
  output logic [NIB_W-1:0] d,
  output logic             dv,
  output logic             er
);
  logic gap;

  assign q_pop = ce && !q_empty && !gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      d   <= '0;
      dv  <= 1'b0;
      er  <= 1'b0;
      gap <= 1'b0;
    end else if (ce) begin
      if (q_pop) begin
        d   <= q_head.nib;
        dv  <= 1'b1;
        er  <= q_head.err;
        gap <= q_head.last;
      end else begin
        d   <= '0;
        dv  <= 1'b0;
        er  <= 1'b0;
        gap <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxa_rmii_lane.sv
module rxa_rmii_lane
  import rxa_pkg::*;
#(
  parameter int HOLD = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce,
  input  logic               q_empty,
  input  rxa_ent_t           q_head,
  output logic               q_pop,
  output logic [DIBIT_W-1:0] d,
  output logic               dv,
  output logic               er
);
  localparam int SPAN = 2 * HOLD;
  localparam int PW   = $clog2(SPAN);
  localparam logic [PW-1:0] PH_MID  = PW'(HOLD - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(SPAN - 1);

  logic          busy;
  logic [PW-1:0] ph;
  rxa_ent_t      cur;
  logic          at_end;

  assign at_end = (ph == PH_LAST);
  assign q_pop  = ce && !q_empty && (!busy || (at_end && !cur.last));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ph   <= '0;
      cur  <= '0;
      d    <= '0;
      dv   <= 1'b0;
      er   <= 1'b0;
    end else if (ce) begin
      if (busy && !at_end) begin
        ph <= ph + 1'b1;
        if (ph == PH_MID) d <= cur.nib[NIB_W-1:DIBIT_W];
      end else if (q_pop) begin
        cur  <= q_head;
        ph   <= '0;
        busy <= 1'b1;
        d    <= q_head.nib[DIBIT_W-1:0];
        dv   <= 1'b1;
        er   <= q_head.err;
      end else begin
        busy <= 1'b0;
        ph   <= '0;
        d    <= '0;
        dv   <= 1'b0;
        er   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxa_rx_adapter.sv
module rxa_rx_adapter
  import rxa_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int DIBIT_HOLD  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_rmii_strap,
  input  logic       mii_ce,
  input  logic       ref_ce,
  input  logic       nib_stb,
  input  logic [3:0] nib_data,
  input  logic       nib_err,
  input  logic       nib_last,
  output logic [3:0] rx_d,
  output logic       rx_dv,
  output logic       rx_er
);
  logic mode_q;

  rxa_ent_t           wr_ent;
  rxa_ent_t           head;
  logic               q_empty;
  logic               q_full;
  logic               pop;
  logic               mii_pop;
  logic               rmii_pop;
  logic [NIB_W-1:0]   mii_d;
  logic               mii_dv;
  logic               mii_er;
  logic [DIBIT_W-1:0] rmii_d;
  logic               rmii_dv;
  logic               rmii_er;

  // strap captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) mode_q <= cfg_rmii_strap;
  end

  assign wr_ent = '{last: nib_last, err: nib_err, nib: nib_data};
  assign pop    = mode_q ? rmii_pop : mii_pop;

  rxa_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .wr    (nib_stb),
    .wdata (wr_ent),
    .rd    (pop),
    .rdata (head),
    .empty (q_empty),
    .full  (q_full)
  );

  rxa_mii_lane u_mii (
    .clk     (clk),
    .rst     (rst),
    .ce      (mii_ce && !mode_q),
    .q_empty (q_empty),
    .q_head  (head),
    .q_pop   (mii_pop),
    .d       (mii_d),
    .dv      (mii_dv),
    .er      (mii_er)
  );

  rxa_rmii_lane #(.HOLD(DIBIT_HOLD)) u_rmii (
    .clk     (clk),
    .rst     (rst),
    .ce      (ref_ce && mode_q),
    .q_empty (q_empty),
    .q_head  (head),
    .q_pop   (rmii_pop),
    .d       (rmii_d),
    .dv      (rmii_dv),
    .er      (rmii_er)
  );

  // both lanes are registered; the static mode only steers them
  always_comb begin
    if (mode_q) begin
      rx_d  = {{(NIB_W-DIBIT_W){1'b0}}, rmii_d};
      rx_dv = rmii_dv;
      rx_er = rmii_er;
    end else begin
      rx_d  = mii_d;
      rx_dv = mii_dv;
      rx_er = mii_er;
    end
  end
endmodule

// File: rtl/rxa_chk.sv
module rxa_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode,
  input logic       mii_ce,
  input logic       ref_ce,
  input logic [3:0] rx_d,
  input logic       rx_dv,
  input logic       rx_er
);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rx_dv |-> (rx_d == 4'd0 && !rx_er));

  a_r4_rmii_upper_zero: assert property (@(posedge clk) disable iff (rst)
    mode |-> (rx_d[3:2] == 2'd0));

  a_r1_mode_fixed: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode));

  a_r2_mii_hold: assert property (@(posedge clk) disable iff (rst)
    (!mode && !$past(rst) && !$past(mii_ce)) |->
      ($stable(rx_d) && $stable(rx_dv) && $stable(rx_er)));

  a_r3_rmii_hold: assert property (@(posedge clk) disable iff (rst)
    (mode && !$past(rst) && !$past(ref_ce)) |->
      ($stable(rx_d) && $stable(rx_dv) && $stable(rx_er)));
endmodule

bind rxa_rx_adapter rxa_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .mode   (mode_q),
  .mii_ce (mii_ce),
  .ref_ce (ref_ce),
  .rx_d   (rx_d),
  .rx_dv  (rx_dv),
  .rx_er  (rx_er)
);

// File: tb/rxa_rx_adapter_bench.sv
`timescale 1ns/1ps
module rxa_rx_adapter_bench;
  localparam int MII_DIV = 4;
  localparam int REF_DIV = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strap = 1'b0;
  logic       mii_ce = 1'b0;
  logic       ref_ce = 1'b0;
  logic       nib_stb = 1'b0;
  logic [3:0] nib_data = 4'd0;
  logic       nib_err = 1'b0;
  logic       nib_last = 1'b0;
  logic [3:0] rx_d;
  logic       rx_dv;
  logic       rx_er;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit run = 1'b0;
  bit watch_rmii = 1'b0;
  int cnt = 0;
  int nlog = 0;
  logic [3:0] log_d  [64];
  logic       log_dv [64];
  logic       log_er [64];

  always #2.5 clk = ~clk;

  rxa_rx_adapter u_rxa_rx_adapter (
    .clk(clk), .rst(rst), .cfg_rmii_strap(strap),
    .mii_ce(mii_ce), .ref_ce(ref_ce),
    .nib_stb(nib_stb), .nib_data(nib_data), .nib_err(nib_err), .nib_last(nib_last),
    .rx_d(rx_d), .rx_dv(rx_dv), .rx_er(rx_er)
  );

  // log outputs after each enabled edge, then drive the next enable
  always @(negedge clk) begin
    if ((mii_ce || ref_ce) && nlog < 64) begin
      log_d[nlog]  = rx_d;
      log_dv[nlog] = rx_dv;
      log_er[nlog] = rx_er;
      nlog++;
    end
    if (run) cnt++; else cnt = 0;
    mii_ce = run && !watch_rmii && (cnt % MII_DIV == 1);
    ref_ce = run &&  watch_rmii && (cnt % REF_DIV == 1);
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst = 1'b1;
    strap = mode;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    strap = !mode;  // R1: later strap changes must not matter
    nlog = 0;
  endtask

  task automatic push(logic [3:0] n, logic e, logic l);
    @(negedge clk);
    nib_stb = 1'b1; nib_data = n; nib_err = e; nib_last = l;
    @(negedge clk);
    nib_stb = 1'b0; nib_data = 4'd0; nib_err = 1'b0; nib_last = 1'b0;
  endtask

  task automatic run_slots(int n);
    @(posedge clk);
    run = 1'b1;
    while (nlog < n) @(posedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic slot_chk(string tag, int i, bit dv, logic [3:0] d, bit er);
    chk($sformatf("%s slot%0d dv", tag, i), int'(log_dv[i]), int'(dv));
    chk($sformatf("%s slot%0d d", tag, i), int'(log_d[i]), int'(d));
    chk($sformatf("%s slot%0d er", tag, i), int'(log_er[i]), int'(er));
  endtask

  // R10: outputs zero in and after reset
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 d in reset", int'(rx_d), 0);
    chk("R10 dv in reset", int'(rx_dv), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 d after reset", int'(rx_d), 0);
    chk("R10 dv after reset", int'(rx_dv), 0);
    chk("R10 er after reset", int'(rx_er), 0);
  endtask

  // R2 R6 R7 R8 R1: two frames back to back on the 4-bit bus
  task automatic t_mii_frames();
    do_reset(1'b0);
    push(4'h1, 0, 0); push(4'h2, 0, 0); push(4'h3, 1, 0);
    push(4'h4, 0, 0); push(4'h5, 0, 1);
    push(4'hA, 0, 0); push(4'hB, 1, 0); push(4'hC, 0, 1);
    run_slots(10);
    slot_chk("R2", 0, 1, 4'h1, 0);
    slot_chk("R2", 1, 1, 4'h2, 0);
    slot_chk("R6", 2, 1, 4'h3, 1);
    slot_chk("R2", 3, 1, 4'h4, 0);
    slot_chk("R2", 4, 1, 4'h5, 0);
    slot_chk("R7", 5, 0, 4'h0, 0);
    slot_chk("R2", 6, 1, 4'hA, 0);
    slot_chk("R6", 7, 1, 4'hB, 1);
    slot_chk("R1", 8, 1, 4'hC, 0);
    slot_chk("R8", 9, 0, 4'h0, 0);
  endtask

  // R9: exact depth then one extra push that is dropped
  task automatic t_fifo_depth();
    do_reset(1'b0);
    for (int i = 0; i < 16; i++) push(4'(i), 0, (i == 15));
    push(4'h7, 0, 0);
    run_slots(18);
    for (int i = 0; i < 16; i++) slot_chk("R9", i, 1, 4'(i), 0);
    slot_chk("R7", 16, 0, 4'h0, 0);
    slot_chk("R9 overflow", 17, 0, 4'h0, 0);
  endtask

  // R3 R4 R6 R7 R1: dibit order and hold length on the 2-bit bus
  task automatic t_rmii_frame();
    do_reset(1'b1);
    watch_rmii = 1'b1;
    push(4'hB, 0, 0);   // low dibit 3, high dibit 2
    push(4'h6, 1, 1);   // low dibit 2, high dibit 1
    run_slots(42);
    for (int i = 0; i < 10; i++) slot_chk("R3 nib0 lo", i, 1, 4'h3, 0);
    for (int i = 10; i < 20; i++) slot_chk("R3 nib0 hi", i, 1, 4'h2, 0);
    for (int i = 20; i < 30; i++) slot_chk("R6 nib1 lo", i, 1, 4'h2, 1);
    for (int i = 30; i < 40; i++) slot_chk("R4 nib1 hi", i, 1, 4'h1, 1);
    slot_chk("R7 rmii", 40, 0, 4'h0, 0);
    slot_chk("R1 rmii", 41, 0, 4'h0, 0);
    watch_rmii = 1'b0;
  endtask

  // R8: queue runs dry mid-frame on the 2-bit bus
  task automatic t_rmii_underrun();
    do_reset(1'b1);
    watch_rmii = 1'b1;
    push(4'hC, 0, 0);
    run_slots(22);
    chk("R3 underrun lo", int'(log_d[0]), 0);
    chk("R3 underrun hi", int'(log_d[19]), 3);
    slot_chk("R8 rmii", 20, 0, 4'h0, 0);
    slot_chk("R8 rmii", 21, 0, 4'h0, 0);
    watch_rmii = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_mii_frames();
    t_fifo_depth();
    t_rmii_frame();
    t_rmii_underrun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule